// File: doc/BRIEF.md
# Mailbox Dual-Port RAM

This block is a word-addressed memory with two fully independent access ports, called left and right. Each port has its own select, write strobe, output enable, address, write data and read data. Both ports work on one shared clock. Each port can read or write any word in any cycle. Reads are registered and return their data one cycle after the request.

The two highest addresses do two jobs. They are normal storage words, and they also act as doorbells between the ports. When one port writes the other port's mailbox word, the other port's active-low interrupt output goes low. The receiving port brings that output high again by making a read access to its own mailbox word.

Each port also has an active-low busy input, which an external arbiter drives. While a port's busy input is low, that port cannot write and cannot change any interrupt flag. It can still read.

Top module: `mbox_dpram`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits. A port writes its data into the addressed word at the rising clock edge when its select is low, its write strobe is low and its busy input is high.
- R2: A port makes a read access when its select is low, its output enable is low and its write strobe is high. After the next rising edge, its read-valid output is 1 and its read data holds the addressed word. If the other port writes the same word in that same cycle, the read returns the previous content.
- R3: A port whose select is high neither writes nor reads, and its read-valid output is 0 after the next edge. A port with output enable high also shows read-valid 0 after the next edge.
- R4: A right-port write to address 2^ADDR_W-2 (0x7FE at the default width) drives leftIrqN low after the edge. A left-port write to that address leaves both interrupt outputs unchanged.
- R5: A left-port access to address 2^ADDR_W-2 with select low, output enable low and busy high drives leftIrqN high after the edge. The level of the write strobe does not matter, and the write itself still takes place.
- R6: A left-port write to address 2^ADDR_W-1 (0x7FF) drives rightIrqN low. A right-port access to that address with select and output enable low drives rightIrqN high again. A right-port write to that address does not touch rightIrqN.
- R7: The two mailbox words store and return data exactly like every other word.
- R8: While a port's busy input is low, its write does not change memory, does not set the other port's flag and does not clear its own flag. Its reads still return data.
- R9: If a set and a clear hit the same flag in the same cycle, the flag ends up low (asserted).
- R10: A synchronous active-low reset drives both interrupt outputs high and both read-valid outputs to 0. The memory contents are not cleared.
- R11: If both ports write the same word in the same cycle, the word keeps the left port's data.
- R12: An access to a mailbox word with output enable high, or with select high, leaves that port's interrupt output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Synchronous reset, active low |
| leftSelN | input | 1 | Left port select, active low |
| leftWrN | input | 1 | Left write strobe, low = write, high = read |
| leftOutEnN | input | 1 | Left output enable, active low |
| leftBusyN | input | 1 | Left busy from arbiter, low blocks writes and flag changes |
| leftAddr | input | ADDR_W | Left word address |
| leftWrData | input | DATA_W | Left write data |
| leftRdData | output | DATA_W | Left registered read data |
| leftRdValid | output | 1 | Left read data is valid (0 stands for a floating bus) |
| leftIrqN | output | 1 | Left interrupt flag, active low |
| rightSelN | input | 1 | Right port select, active low |
| rightWrN | input | 1 | Right write strobe, low = write, high = read |
| rightOutEnN | input | 1 | Right output enable, active low |
| rightBusyN | input | 1 | Right busy from arbiter, low blocks writes and flag changes |
| rightAddr | input | ADDR_W | Right word address |
| rightWrData | input | DATA_W | Right write data |
| rightRdData | output | DATA_W | Right registered read data |
| rightRdValid | output | 1 | Right read data is valid (0 stands for a floating bus) |
| rightIrqN | output | 1 | Right interrupt flag, active low |

## Verification
A write and any flag set or clear it causes both take effect at the first rising edge after the inputs are applied. Read data and read-valid also appear after that same edge, so every result is due exactly one cycle after its stimulus. The bench applies inputs at the falling edge and compares at the next falling edge, which falls halfway between the edge that produces a result and the edge that consumes the next stimulus. Stored words are checked with a separate read issued in a later cycle, so each check observes exactly one register stage.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Per-port strobes from the decoder to the storage datapath; index 0 = left, 1 = right
  typedef struct packed {
    logic [1:0] wrEn;
    logic [1:0] rdEn;
  } ctrlStb_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             selN,
  input  logic [1:0]             wrN,
  input  logic [1:0]             outEnN,
  input  logic [1:0]             busyN,
  input  logic [1:0][ADDR_W-1:0] addr,
  output ctrlStb_t               stb,
  output logic [1:0]             irqN
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic [1:0] wrEnV;
  logic [1:0] rdEnV;
  logic [1:0] setPeer;
  logic [1:0] clrOwn;

  for (genvar p = 0; p < 2; p++) begin : g_dec
    // Port p owns the mailbox that clears its own flag; writing the other one rings the peer
    localparam logic [ADDR_W-1:0] OWN_BOX  = (p == 0) ? TOP_ADDR - 1'b1 : TOP_ADDR;
    localparam logic [ADDR_W-1:0] PEER_BOX = (p == 0) ? TOP_ADDR : TOP_ADDR - 1'b1;
    logic access;
    assign access     = !selN[p];
    assign wrEnV[p]   = access & !wrN[p] & busyN[p];
    assign rdEnV[p]   = access & !outEnN[p] & wrN[p];
    assign setPeer[p] = wrEnV[p] & (addr[p] == PEER_BOX);
    assign clrOwn[p]  = access & !outEnN[p] & busyN[p] & (addr[p] == OWN_BOX);
  end

  assign stb = '{wrEn: wrEnV, rdEn: rdEnV};

  for (genvar q = 0; q < 2; q++) begin : g_flag
    logic flagN;
    always_ff @(posedge clk) begin
      if (!rstN)                flagN <= 1'b1;
      else if (setPeer[1 - q])  flagN <= 1'b0;  // a new message outranks an acknowledge
      else if (clrOwn[q])       flagN <= 1'b1;
    end
    assign irqN[q] = flagN;
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStb_t               stb,
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0][DATA_W-1:0] wrData,
  output logic [1:0][DATA_W-1:0] rdData,
  output logic [1:0]             rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right first, left last: on a same-word collision the left value lands
  always_ff @(posedge clk) begin
    if (stb.wrEn[1]) mem[addr[1]] <= wrData[1];
    if (stb.wrEn[0]) mem[addr[0]] <= wrData[0];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DATA_W-1:0] dataQ;
    logic              validQ;
    always_ff @(posedge clk) begin
      if (stb.rdEn[p]) dataQ <= mem[addr[p]];
    end
    always_ff @(posedge clk) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= stb.rdEn[p];
    end
    assign rdData[p]  = dataQ;
    assign rdValid[p] = validQ;
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftSelN,
  input  logic              leftWrN,
  input  logic              leftOutEnN,
  input  logic              leftBusyN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftWrData,
  output logic [DATA_W-1:0] leftRdData,
  output logic              leftRdValid,
  output logic              leftIrqN,
  input  logic              rightSelN,
  input  logic              rightWrN,
  input  logic              rightOutEnN,
  input  logic              rightBusyN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightWrData,
  output logic [DATA_W-1:0] rightRdData,
  output logic              rightRdValid,
  output logic              rightIrqN
);
  ctrlStb_t                 stb;
  logic [1:0][ADDR_W-1:0]   addrV;
  logic [1:0][DATA_W-1:0]   wrDataV;
  logic [1:0][DATA_W-1:0]   rdDataV;
  logic [1:0]               rdValidV;
  logic [1:0]               irqNV;

  assign addrV   = {rightAddr, leftAddr};
  assign wrDataV = {rightWrData, leftWrData};

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .selN   ({rightSelN, leftSelN}),
    .wrN    ({rightWrN, leftWrN}),
    .outEnN ({rightOutEnN, leftOutEnN}),
    .busyN  ({rightBusyN, leftBusyN}),
    .addr   (addrV),
    .stb    (stb),
    .irqN   (irqNV)
  );

  mbox_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .addr    (addrV),
    .wrData  (wrDataV),
    .rdData  (rdDataV),
    .rdValid (rdValidV)
  );

  assign leftRdData   = rdDataV[0];
  assign rightRdData  = rdDataV[1];
  assign leftRdValid  = rdValidV[0];
  assign rightRdValid = rdValidV[1];
  assign leftIrqN     = irqNV[0];
  assign rightIrqN    = irqNV[1];
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              leftSelN,
  input logic              leftWrN,
  input logic              leftOutEnN,
  input logic              leftBusyN,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              leftRdValid,
  input logic              leftIrqN,
  input logic              rightSelN,
  input logic              rightWrN,
  input logic              rightOutEnN,
  input logic              rightBusyN,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              rightRdValid,
  input logic              rightIrqN
);
  localparam logic [ADDR_W-1:0] HI_BOX = '1;
  localparam logic [ADDR_W-1:0] LO_BOX = HI_BOX - 1'b1;

  logic ringLeft, ringRight, ackLeft, ackRight;
  assign ringLeft  = !rightSelN && !rightWrN && rightBusyN && (rightAddr == LO_BOX);
  assign ringRight = !leftSelN && !leftWrN && leftBusyN && (leftAddr == HI_BOX);
  assign ackLeft   = !leftSelN && !leftOutEnN && leftBusyN && (leftAddr == LO_BOX);
  assign ackRight  = !rightSelN && !rightOutEnN && rightBusyN && (rightAddr == HI_BOX);

  assert_ring_left_R4: assert property (@(posedge clk) disable iff (!rstN)
    ringLeft |=> !leftIrqN);
  assert_ack_left_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackLeft && !ringLeft) |=> leftIrqN);
  assert_ring_right_R6: assert property (@(posedge clk) disable iff (!rstN)
    ringRight |=> !rightIrqN);
  assert_ack_right_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackRight && !ringRight) |=> rightIrqN);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!leftBusyN && !ringLeft) |=> $stable(leftIrqN));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ringRight && ackRight) |=> !rightIrqN);
  assert_desel_left_R3: assert property (@(posedge clk) disable iff (!rstN)
    leftSelN |=> !leftRdValid);
  assert_desel_right_R3: assert property (@(posedge clk) disable iff (!rstN)
    rightSelN |=> !rightRdValid);
  assert_reset_R10: assert property (@(posedge clk)
    !rstN |=> (leftIrqN && rightIrqN && !leftRdValid && !rightRdValid));
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .leftSelN     (leftSelN),
  .leftWrN      (leftWrN),
  .leftOutEnN   (leftOutEnN),
  .leftBusyN    (leftBusyN),
  .leftAddr     (leftAddr),
  .leftRdValid  (leftRdValid),
  .leftIrqN     (leftIrqN),
  .rightSelN    (rightSelN),
  .rightWrN     (rightWrN),
  .rightOutEnN  (rightOutEnN),
  .rightBusyN   (rightBusyN),
  .rightAddr    (rightAddr),
  .rightRdValid (rightRdValid),
  .rightIrqN    (rightIrqN)
);

// File: tb/tb_mbox_dpram.sv
module tb_mbox_dpram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int WORDS = 1 << AW;
  localparam logic [AW-1:0] HI_BOX = '1;
  localparam logic [AW-1:0] LO_BOX = HI_BOX - 1'b1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lSelN, lWrN, lOeN, lBusyN;
  logic [AW-1:0] lAddr;
  logic [DW-1:0] lWd, lRd;
  logic lValid, lIrqN;
  logic rSelN, rWrN, rOeN, rBusyN;
  logic [AW-1:0] rAddr;
  logic [DW-1:0] rWd, rRd;
  logic rValid, rIrqN;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [DW-1:0] shadow [WORDS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN),
    .leftSelN(lSelN), .leftWrN(lWrN), .leftOutEnN(lOeN), .leftBusyN(lBusyN),
    .leftAddr(lAddr), .leftWrData(lWd), .leftRdData(lRd), .leftRdValid(lValid),
    .leftIrqN(lIrqN),
    .rightSelN(rSelN), .rightWrN(rWrN), .rightOutEnN(rOeN), .rightBusyN(rBusyN),
    .rightAddr(rAddr), .rightWrData(rWd), .rightRdData(rRd), .rightRdValid(rValid),
    .rightIrqN(rIrqN)
  );

  task automatic setL(input logic sel, input logic wr, input logic oe, input logic busy,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    lSelN = sel; lWrN = wr; lOeN = oe; lBusyN = busy; lAddr = a; lWd = d;
  endtask

  task automatic setR(input logic sel, input logic wr, input logic oe, input logic busy,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    rSelN = sel; rWrN = wr; rOeN = oe; rBusyN = busy; rAddr = a; rWd = d;
  endtask

  task automatic idle();
    setL(1, 1, 1, 1, '0, '0);
    setR(1, 1, 1, 1, '0, '0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    idle();
    rstN = 1'b0;
    tick(); tick();
    check("R10 reset leftIrqN", lIrqN, 1);
    check("R10 reset rightIrqN", rIrqN, 1);
    check("R10 reset leftRdValid", lValid, 0);
    check("R10 reset rightRdValid", rValid, 0);
    rstN = 1'b1;

    // R1 R7: left fills every word, right reads them all back
    for (int a = 0; a < WORDS; a++) begin
      setL(0, 0, 1, 1, AW'(a), DW'(a * 29 + 3));
      shadow[a] = DW'(a * 29 + 3);
      tick();
    end
    idle();
    check("R6 left write hi box rings right", rIrqN, 0);
    check("R4 left write lo box leaves left flag", lIrqN, 1);
    for (int a = 0; a < WORDS; a++) begin
      setR(0, 1, 0, 1, AW'(a), '0);
      tick();
      check("R2 right read valid", rValid, 1);
      check("R1 R7 right read data", rRd, shadow[a]);
    end
    check("R6 right read hi box clears", rIrqN, 1);
    idle(); tick();
    check("R3 deselected rdValid", rValid, 0);

    // R1 R7: right fills every word, left reads them back
    for (int a = 0; a < WORDS; a++) begin
      setR(0, 0, 1, 1, AW'(a), DW'(255 - a * 13));
      shadow[a] = DW'(255 - a * 13);
      tick();
    end
    idle();
    check("R4 right write lo box rings left", lIrqN, 0);
    check("R6 right write hi box no effect", rIrqN, 1);
    for (int a = 0; a < WORDS; a++) begin
      setL(0, 1, 0, 1, AW'(a), '0);
      tick();
      check("R2 left read valid", lValid, 1);
      check("R1 R7 left read data", lRd, shadow[a]);
    end
    check("R5 left read lo box clears", lIrqN, 1);
    idle();

    // R5 with the write strobe low: clear and write both happen
    setR(0, 0, 1, 1, LO_BOX, 8'h5A); tick(); idle();
    check("R4 ring left", lIrqN, 0);
    setL(0, 0, 0, 1, LO_BOX, 8'hA5); shadow[LO_BOX] = 8'hA5; tick(); idle();
    check("R5 clear with write strobe low", lIrqN, 1);
    setL(0, 1, 0, 1, LO_BOX, '0); tick(); idle();
    check("R5 R7 mailbox holds written data", lRd, 8'hA5);

    // R12: output enable high or select high leaves the flag
    setR(0, 0, 1, 1, LO_BOX, 8'h42); shadow[LO_BOX] = 8'h42; tick(); idle();
    setL(0, 1, 1, 1, LO_BOX, '0); tick(); idle();
    check("R12 oe high no clear", lIrqN, 0);
    check("R3 oe high rdValid", lValid, 0);
    setL(1, 1, 0, 1, LO_BOX, '0); tick(); idle();
    check("R12 sel high no clear", lIrqN, 0);

    // R9 set beats clear; R2 read-during-write returns old word
    setR(0, 0, 1, 1, LO_BOX, 8'h33);
    setL(0, 1, 0, 1, LO_BOX, '0);
    tick(); idle();
    check("R9 set wins", lIrqN, 0);
    check("R2 read during write old data", lRd, 8'h42);
    shadow[LO_BOX] = 8'h33;
    setL(0, 1, 0, 1, LO_BOX, '0); tick(); idle();
    check("R5 clear after collision", lIrqN, 1);
    check("R9 new message kept", lRd, 8'h33);

    // R8: busy blocks write, set and clear but not reads
    setL(0, 0, 1, 0, 4'd3, 8'hEE); tick(); idle();
    setR(0, 1, 0, 1, 4'd3, '0); tick(); idle();
    check("R8 busy blocks write", rRd, shadow[3]);
    setL(0, 0, 1, 0, HI_BOX, 8'h99); tick(); idle();
    check("R8 busy blocks set", rIrqN, 1);
    setR(0, 0, 1, 0, LO_BOX, 8'h77); tick(); idle();
    check("R8 right busy blocks set", lIrqN, 1);
    setR(0, 0, 1, 1, LO_BOX, 8'h61); shadow[LO_BOX] = 8'h61; tick(); idle();
    setL(0, 1, 0, 0, LO_BOX, '0); tick(); idle();
    check("R8 busy blocks clear", lIrqN, 0);
    check("R8 busy read valid", lValid, 1);
    check("R8 busy read data", lRd, 8'h61);
    setL(0, 1, 0, 1, LO_BOX, '0); tick(); idle();
    check("R5 clear after busy", lIrqN, 1);

    // R3: deselected write has no effect
    setL(1, 0, 0, 1, 4'd5, 8'h11); tick(); idle();
    check("R3 deselected rdValid", lValid, 0);
    setR(0, 1, 0, 1, 4'd5, '0); tick(); idle();
    check("R3 deselected no write", rRd, shadow[5]);

    // R11: same-word collision keeps left data
    setL(0, 0, 1, 1, 4'd7, 8'h77);
    setR(0, 0, 1, 1, 4'd7, 8'h88);
    tick(); idle();
    setR(0, 1, 0, 1, 4'd7, '0); tick(); idle();
    check("R11 collision left wins", rRd, 8'h77);

    // R10: reset mid-run releases both flags
    setL(0, 0, 1, 1, HI_BOX, 8'h01);
    setR(0, 0, 1, 1, LO_BOX, 8'h02);
    tick(); idle();
    check("R4 both ring left", lIrqN, 0);
    check("R6 both ring right", rIrqN, 0);
    setR(0, 1, 0, 1, 4'd0, '0);
    rstN = 1'b0; tick(); idle();
    check("R10 mid reset leftIrqN", lIrqN, 1);
    check("R10 mid reset rightIrqN", rIrqN, 1);
    check("R10 mid reset rdValid", rValid, 0);
    rstN = 1'b1; tick();

    summary();
  end
endmodule